// File: doc/BRIEF.md
# Output Port Token Rate Limiter

This block paces the packets that one output port may start. It keeps a debt counter in tokens. Every packet start adds a charge to the counter, and a fixed amount drains from it on every clock. The charge is a per-packet cost, scaled by 256, plus a per-word cost multiplied by the packet length in 8-byte words. While the debt, taken in units of 256 tokens, stands above a configured burst ceiling, the send-permit output is held low and the port scheduler must not begin a new packet.

The three costs let one datapath limit either rate. For a packet rate, the host sets the word cost to zero. For a bit rate, the word cost is 64 times the token cost of one bit, where one bit costs sixteen times the clock frequency divided by the target bit rate. In that mode the packet cost also covers the 24 bytes of gap, preamble and CRC that never appear as words. The host computes these values and writes them through a small register port. Each write is tagged with a port number, and the block accepts only writes tagged with its own number.

Top module: `port_rate_limiter`

## Requirements
- R1: After reset the debt is zero, all three configuration values are zero, and the permit is high.
- R2: A packet start adds the packet-cost register times 256 to the debt, at the clock edge that samples the strobe.
- R3: A packet start also adds the word-cost register times the word count given with the strobe.
- R4: Every clock removes 16 tokens from the debt, and the debt stops at zero rather than going below it.
- R5: The permit is low exactly when the debt shifted right by 8 is greater than the limit register. Equality still permits. The permit reflects the debt and limit values as updated at the most recent edge.
- R6: A write updates a register only when cfg_we is high and cfg_port equals the block's port parameter. The selector value 0 picks the packet cost, 1 the word cost and 2 the limit. Selector 3 writes nothing.
- R7: A packet start that arrives while the permit is low is still charged in full. The block never aborts or discounts a packet.
- R8: The debt saturates at its all-ones value instead of wrapping when a charge would overflow it.
- R9: When a charge and the drain fall in the same cycle, the new debt is the drained value (floored at zero) plus the charge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_port | input | PORT_W (6) | Port number the write is addressed to |
| cfg_sel | input | 2 | Register select: 0 packet cost, 1 word cost, 2 limit, 3 none |
| cfg_data | input | CFG_W (24) | Write data, truncated to the selected register's width |
| pkt_start | input | 1 | One-cycle strobe when the port begins a packet |
| pkt_words | input | WORDS_W (11) | Packet length in 8-byte words, valid with pkt_start |
| send_ok | output | 1 | Permit to start a new packet |

## Verification
The bench builds the block with its default parameters: port number 5, 16-bit cost fields, a 24-bit limit, packets up to 1024 words, a 33-bit debt and the registered permit variant. These widths let ordinary random traffic use small costs and cross the limit boundary many times. Writing every cost at its maximum then reaches the top of the debt range after 103 maximal packets. At that count a wrapping counter would fall back below the largest limit, so wrapping shows up at the permit output. Directed sequences place the debt exactly at the limit and one token step above it, send a packet into a closed permit, and address writes to a different port and to the unused selector.

// File: rtl/rl_pkg.sv
package rl_pkg;

   typedef enum logic [1:0] {
      SEL_PKT_COST  = 2'd0,
      SEL_WORD_COST = 2'd1,
      SEL_LIMIT     = 2'd2,
      SEL_NONE      = 2'd3
   } rl_sel_e;

   localparam int TOKEN_SHIFT = 8;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/rl_cfg_regs.sv
module rl_cfg_regs
   import rl_pkg::*;
#(
   parameter int PORT_W  = 6,
   parameter int MY_PORT = 5,
   parameter int PC_W    = 16,
   parameter int WC_W    = 16,
   parameter int LIM_W   = 24,
   parameter int CFG_W   = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PORT_W-1:0] wr_port,
   input  logic [1:0]        wr_sel,
   input  logic [CFG_W-1:0]  wr_data,
   output logic              wr_hit,
   output logic [PC_W-1:0]   pkt_cost_q,
   output logic [WC_W-1:0]   word_cost_q,
   output logic [LIM_W-1:0]  lim_q,
   output logic [LIM_W-1:0]  lim_d
);

   localparam logic [PORT_W-1:0] OWN_ID = PORT_W'(MY_PORT);

   if (CFG_W < PC_W || CFG_W < WC_W || CFG_W < LIM_W) begin : g_bad_cfg_w
      $error("rl_cfg_regs: CFG_W narrower than a register");
   end
   if (MY_PORT >= (1 << PORT_W)) begin : g_bad_port
      $error("rl_cfg_regs: MY_PORT does not fit PORT_W");
   end

   rl_sel_e sel;
   assign sel    = rl_sel_e'(wr_sel);
   assign wr_hit = wr_en && (wr_port == OWN_ID) && (sel != SEL_NONE);

   always_comb begin
      lim_d = lim_q;
      if (wr_hit && sel == SEL_LIMIT) lim_d = wr_data[LIM_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pkt_cost_q  <= '0;
         word_cost_q <= '0;
         lim_q       <= '0;
      end else begin
         lim_q <= lim_d;
         if (wr_hit && sel == SEL_PKT_COST)  pkt_cost_q  <= wr_data[PC_W-1:0];
         if (wr_hit && sel == SEL_WORD_COST) word_cost_q <= wr_data[WC_W-1:0];
      end
   end

   assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_hit) |-> ($stable(pkt_cost_q) && $stable(word_cost_q) && $stable(lim_q)));

endmodule

// File: rtl/rl_charge_calc.sv
module rl_charge_calc
   import rl_pkg::*;
#(
   parameter int PC_W    = 16,
   parameter int WC_W    = 16,
   parameter int WORDS_W = 11,
   parameter int ACC_W   = 33,
   parameter bit SHIFT_ADD = 0
) (
   input  logic               start,
   input  logic [WORDS_W-1:0] words,
   input  logic [PC_W-1:0]    pkt_cost,
   input  logic [WC_W-1:0]    word_cost,
   output logic [ACC_W-1:0]   charge
);

   if (ACC_W < PC_W + TOKEN_SHIFT + 1 || ACC_W < WC_W + WORDS_W + 1) begin : g_bad_acc
      $error("rl_charge_calc: ACC_W too narrow for the largest charge");
   end

   logic [ACC_W-1:0] pkt_part;
   logic [ACC_W-1:0] word_part;

   assign pkt_part = ACC_W'(pkt_cost) << TOKEN_SHIFT;

   if (SHIFT_ADD) begin : g_shift_add
      logic [ACC_W-1:0] partial [WORDS_W+1];
      assign partial[0] = '0;
      for (genvar b = 0; b < WORDS_W; b++) begin : g_bit
         assign partial[b+1] = partial[b] +
                               (words[b] ? (ACC_W'(word_cost) << b) : '0);
      end
      assign word_part = partial[WORDS_W];
   end else begin : g_mult
      assign word_part = ACC_W'(word_cost) * ACC_W'(words);
   end

   assign charge = start ? (pkt_part + word_part) : '0;

endmodule

// File: rtl/rl_debt_acc.sv
module rl_debt_acc #(
   parameter int ACC_W = 33,
   parameter int DRAIN = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ACC_W-1:0] charge,
   output logic [ACC_W-1:0] debt_q,
   output logic [ACC_W-1:0] debt_d
);

   localparam logic [ACC_W-1:0] DRAIN_V = ACC_W'(DRAIN);

   if (DRAIN < 1 || DRAIN >= (1 << 20)) begin : g_bad_drain
      $error("rl_debt_acc: DRAIN out of range");
   end

   logic [ACC_W-1:0] drained;
   logic [ACC_W:0]   sum;

   always_comb begin
      drained = (debt_q >= DRAIN_V) ? (debt_q - DRAIN_V) : '0;
      sum     = {1'b0, drained} + {1'b0, charge};
      debt_d  = sum[ACC_W] ? '1 : sum[ACC_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) debt_q <= '0;
      else        debt_q <= debt_d;
   end

   assert_drain_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, debt_q} + {1'b0, DRAIN_V}) >= {1'b0, $past(debt_q)});

   assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(charge) != '0 && $past(debt_q) >= DRAIN_V) |->
         (debt_q > ($past(debt_q) - DRAIN_V)));

endmodule

// File: rtl/port_rate_limiter.sv
module port_rate_limiter
   import rl_pkg::*;
#(
   parameter int PORT_W     = 6,
   parameter int MY_PORT    = 5,
   parameter int PC_W       = 16,
   parameter int WC_W       = 16,
   parameter int LIM_W      = 24,
   parameter int MAX_WORDS  = 1024,
   parameter int DRAIN      = 16,
   parameter bit PERMIT_REG = 1,
   parameter bit SHIFT_ADD  = 0,
   localparam int WORDS_W   = $clog2(MAX_WORDS + 1),
   localparam int CFG_W     = max3(PC_W, WC_W, LIM_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [PORT_W-1:0]  cfg_port,
   input  logic [1:0]         cfg_sel,
   input  logic [CFG_W-1:0]   cfg_data,
   input  logic               pkt_start,
   input  logic [WORDS_W-1:0] pkt_words,
   output logic               send_ok
);

   localparam int ACC_W = max3(PC_W + TOKEN_SHIFT, WC_W + WORDS_W,
                               LIM_W + TOKEN_SHIFT) + 1;

   if (MAX_WORDS < 1) begin : g_bad_words
      $error("port_rate_limiter: MAX_WORDS must be positive");
   end

   logic              wr_hit;
   logic [PC_W-1:0]   pkt_cost_q;
   logic [WC_W-1:0]   word_cost_q;
   logic [LIM_W-1:0]  lim_q, lim_d;
   logic [ACC_W-1:0]  charge, debt_q, debt_d;

   rl_cfg_regs #(
      .PORT_W(PORT_W), .MY_PORT(MY_PORT), .PC_W(PC_W), .WC_W(WC_W),
      .LIM_W(LIM_W), .CFG_W(CFG_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_port(cfg_port),
      .wr_sel(cfg_sel), .wr_data(cfg_data), .wr_hit(wr_hit),
      .pkt_cost_q(pkt_cost_q), .word_cost_q(word_cost_q),
      .lim_q(lim_q), .lim_d(lim_d)
   );

   rl_charge_calc #(
      .PC_W(PC_W), .WC_W(WC_W), .WORDS_W(WORDS_W), .ACC_W(ACC_W),
      .SHIFT_ADD(SHIFT_ADD)
   ) u_charge (
      .start(pkt_start), .words(pkt_words), .pkt_cost(pkt_cost_q),
      .word_cost(word_cost_q), .charge(charge)
   );

   rl_debt_acc #(.ACC_W(ACC_W), .DRAIN(DRAIN)) u_acc (
      .clk(clk), .rst_n(rst_n), .charge(charge),
      .debt_q(debt_q), .debt_d(debt_d)
   );

   if (PERMIT_REG) begin : g_permit_reg
      logic permit_q;
      always_ff @(posedge clk) begin
         if (!rst_n) permit_q <= 1'b1;
         else        permit_q <= (debt_d >> TOKEN_SHIFT) <= ACC_W'(lim_d);
      end
      assign send_ok = permit_q;

      assert_permit_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
         send_ok == ((debt_q >> TOKEN_SHIFT) <= ACC_W'(lim_q)));
   end else begin : g_permit_comb
      assign send_ok = (debt_q >> TOKEN_SHIFT) <= ACC_W'(lim_q);

      assert_permit_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
         send_ok == $past((debt_d >> TOKEN_SHIFT) <= ACC_W'(lim_d)));
   end

   assert_fall_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(send_ok) |-> ($past(pkt_start) || $past(wr_hit)));

endmodule

// File: tb/port_rate_limiter_tb_top.sv
module port_rate_limiter_tb_top;

   localparam int  MYP   = 5;
   localparam int  ACCW  = 33;
   localparam longint ACCMAX = (64'd1 << ACCW) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [5:0]  cfg_port = '0;
   logic [1:0]  cfg_sel = '0;
   logic [23:0] cfg_data = '0;
   logic        pkt_start = 1'b0;
   logic [10:0] pkt_words = '0;
   logic        send_ok;

   int checks = 0;
   int fails  = 0;
   longint m_debt = 0, m_pc = 0, m_wc = 0, m_lim = 0;

   always #4 clk = ~clk;

   port_rate_limiter dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_port(cfg_port),
      .cfg_sel(cfg_sel), .cfg_data(cfg_data), .pkt_start(pkt_start),
      .pkt_words(pkt_words), .send_ok(send_ok)
   );

   function automatic bit exp_ok();
      return (m_debt >> 8) <= m_lim;
   endfunction

   task automatic check(input string tag, input bit act, input bit expv);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s: send_ok=%0b expected %0b", tag, act, expv);
      end
   endtask

   task automatic model_step();
      longint ch, d;
      ch = 0;
      if (pkt_start) ch = (m_pc << 8) + m_wc * longint'(pkt_words);
      d = (m_debt >= 16) ? m_debt - 16 : 0;
      d = d + ch;
      m_debt = (d > ACCMAX) ? ACCMAX : d;
      if (cfg_we && cfg_port == 6'(MYP)) begin
         case (cfg_sel)
            2'd0: m_pc  = longint'(cfg_data[15:0]);
            2'd1: m_wc  = longint'(cfg_data[15:0]);
            2'd2: m_lim = longint'(cfg_data);
            default: ;
         endcase
      end
   endtask

   task automatic cyc(input string tag);
      @(posedge clk);
      if (rst_n) model_step();
      #2;
      if (rst_n) check(tag, send_ok, exp_ok());
      cfg_we = 1'b0;
      pkt_start = 1'b0;
   endtask

   task automatic wr(input int port, input int sel, input int data, input string tag);
      cfg_we = 1'b1; cfg_port = 6'(port); cfg_sel = 2'(sel); cfg_data = 24'(data);
      cyc(tag);
   endtask

   task automatic pkt(input int words, input string tag);
      pkt_start = 1'b1; pkt_words = 11'(words);
      cyc(tag);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) cyc(tag);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      #2;
      check("R1 permit during reset", send_ok, 1'b1);
      rst_n = 1'b1;
      idle(2, "R1 idle after reset");
      pkt(1000, "R1 zero costs after reset");
      check("R1 zero costs charge nothing", send_ok, 1'b1);

      // R6: wrong port and unused selector must not change anything
      wr(MYP + 1, 0, 200, "R6 foreign port write");
      wr(MYP, 3, 200, "R6 selector 3 write");
      pkt(5, "R6 packet after ignored writes");
      check("R6 ignored writes keep cost zero", send_ok, 1'b1);

      // R2/R5 boundary: cost 3*256 against limit 2
      wr(MYP, 0, 3, "R6 packet cost write");
      wr(MYP, 2, 2, "R6 limit write");
      pkt(1, "R2 first charge");
      check("R2 768 tokens exceeds limit 2", send_ok, 1'b0);
      pkt(1, "R7 charge while closed");
      check("R7 debt 1520 still closed", send_ok, 1'b0);
      idle(47, "R4 drain toward limit");
      check("R5 debt 768 above limit", send_ok, 1'b0);
      idle(1, "R4 drain step");
      check("R5 debt 752 equal-limit permits", send_ok, 1'b1);
      idle(60, "R4 drain to zero floor");
      wr(MYP, 2, 0, "R6 limit zero");
      check("R4 floor at zero under limit 0", send_ok, 1'b1);

      // R3: word cost 4, limit 1
      wr(MYP, 0, 0, "R6 clear packet cost");
      wr(MYP, 1, 4, "R6 word cost write");
      wr(MYP, 2, 1, "R6 limit 1");
      pkt(100, "R3 400 tokens");
      check("R3 400 tokens within limit", send_ok, 1'b1);
      idle(30, "R4 drain");
      pkt(128, "R3 512 tokens");
      check("R3 512 tokens exceeds limit", send_ok, 1'b0);
      idle(40, "R4 drain after word charge");

      // R9: charge and drain in the same cycle, debt above drain
      wr(MYP, 1, 0, "R6 clear word cost");
      wr(MYP, 0, 1, "R6 packet cost 1");
      pkt(1, "R9 charge 256 from zero");
      check("R9 256 tokens permits at limit 1", send_ok, 1'b1);
      pkt(1, "R9 240+256=496");
      check("R9 496 tokens permits", send_ok, 1'b1);
      pkt(1, "R9 480+256=736");
      check("R9 736 tokens closes", send_ok, 1'b0);
      idle(60, "R4 drain");

      // random traffic
      for (int i = 0; i < 30000; i++) begin
         int r;
         r = int'($urandom_range(0, 99));
         if (r < 2) begin
            cfg_we = 1'b1;
            cfg_port = ($urandom_range(0, 3) == 0) ? 6'($urandom_range(0, 63)) : 6'(MYP);
            cfg_sel = 2'($urandom_range(0, 3));
            cfg_data = (cfg_sel == 2'd2) ? 24'($urandom_range(0, 40))
                     : (cfg_sel == 2'd0) ? 24'($urandom_range(0, 20))
                                         : 24'($urandom_range(0, 8));
         end
         if (r >= 85) begin
            pkt_start = 1'b1;
            pkt_words = 11'($urandom_range(1, 1024));
         end
         cyc("R5 random traffic");
      end

      // R8: saturation; 103 maximal packets would wrap to a small value
      wr(MYP, 0, 16'hFFFF, "R6 max packet cost");
      wr(MYP, 1, 16'hFFFF, "R6 max word cost");
      wr(MYP, 2, 24'hFFFFFF, "R6 max limit");
      for (int i = 0; i < 103; i++) pkt(1024, "R8 maximal packet");
      idle(4, "R8 after saturation");
      check("R8 debt saturated, permit stays low", send_ok, 1'b0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule